// File: doc/BRIEF.md
# Receive Flow-Control Request-to-Send Generator

This block produces the active-low request-to-send pin of a UART receiver, which tells the remote sender whether it may keep sending. It has two modes. In automatic mode it compares the number of bytes waiting in the receive FIFO against a threshold chosen by a 4-bit trigger code. It keeps the request active while the FIFO holds fewer bytes than the threshold. It withdraws the request once the count reaches the threshold. In software mode the request follows a control bit written by firmware.

A polarity input selects whether the pin carries the internal request directly or inverted. A status output returns the level that is actually on the pin, so firmware can read it back. The pin is a single flip-flop, so it cannot glitch, and it settles one clock after any of its inputs changes. The remote sender takes some time to react after the request is withdrawn, so the FIFO that feeds this block must keep spare room above the threshold for bytes already in flight.

Top module: `nrts_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, `rts_n_pin` and `rts_pin_status` become 1 (request inactive under the default inverting polarity), whatever the other inputs are.
- R2: With `auto_en` = 1 and `fifo_count` below the decoded threshold, the internal request is active (1).
- R3: With `auto_en` = 1 and `fifo_count` equal to or above the decoded threshold, the internal request is inactive (0).
- R4: The trigger code `trig_code` decodes to a threshold of 1, 4, 8 and 14 bytes for codes 0, 1, 2 and 3. Codes 4 to 15 decode to 14.
- R5: With `auto_en` = 0 the internal request equals `sw_rts`, and the FIFO count and trigger code have no effect on the pin.
- R6: With `pol_inv` = 1 the pin is the inverse of the internal request. With `pol_inv` = 0 the pin equals the request.
- R7: `rts_pin_status` always equals `rts_n_pin`.
- R8: The pin is registered. It takes the value computed from the inputs sampled at a rising edge, and it does not change between edges. Changing modes therefore takes effect at the next edge without any intermediate pulse.
- R9: A FIFO count above the threshold, up to the largest value `fifo_count` can hold, keeps the request inactive in automatic mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_count | input | CNT_W | Bytes currently held in the receive FIFO |
| trig_code | input | 4 | Threshold select code |
| auto_en | input | 1 | 1 = automatic mode, 0 = software mode |
| sw_rts | input | 1 | Software request bit, used when `auto_en` = 0 |
| pol_inv | input | 1 | 1 = pin is the inverted request, 0 = pin equals the request |
| rts_n_pin | output | 1 | Registered request-to-send pin |
| rts_pin_status | output | 1 | Readback of the level on the pin |

## Verification
For every trigger code the bench drives the counts one below the threshold, equal to it, and at the largest value. An off-by-one comparison would fail at one of the first two. A bad decode of the reserved codes would fail at counts 13 and 14. An unsigned wrap would fail at the largest count. The bench also samples the pin halfway between two edges, right after the inputs change. A combinational output, or a glitch when the mode switches, shows up there as an early change. The bench holds the reset with inputs that would otherwise drive the pin low, so a reset that fails to force the inactive level is caught. Random mixes of mode and polarity expose any swap of the inverted and non-inverted paths, and any leak of the FIFO count into software mode.

// File: rtl/nrts_pkg.sv
package nrts_pkg;

  typedef enum logic {
    MODE_SW   = 1'b0,
    MODE_AUTO = 1'b1
  } rts_mode_e;

  // Trigger code to byte threshold; codes above 3 select the top level.
  function automatic int unsigned trig_level(input logic [3:0] code,
                                             input int unsigned l0,
                                             input int unsigned l1,
                                             input int unsigned l2,
                                             input int unsigned l3);
    case (code)
      4'd0:    trig_level = l0;
      4'd1:    trig_level = l1;
      4'd2:    trig_level = l2;
      default: trig_level = l3;
    endcase
  endfunction

endpackage

// File: rtl/nrts_trig_decode.sv
module nrts_trig_decode #(
  parameter int unsigned CNT_W = 5,
  parameter int unsigned LVL0  = 1,
  parameter int unsigned LVL1  = 4,
  parameter int unsigned LVL2  = 8,
  parameter int unsigned LVL3  = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       trig_code,
  output logic [CNT_W-1:0] level
);
  import nrts_pkg::*;

  localparam int unsigned TOP_LVL = LVL3;

  always_comb begin
    level = CNT_W'(trig_level(trig_code, LVL0, LVL1, LVL2, LVL3));
  end

  // R4: reserved codes fall back to the top level
  a_r4_reserved_top: assert property (@(posedge clk) disable iff (rst)
    (trig_code > 4'd3) |-> (level == CNT_W'(TOP_LVL)));

  // R4: decoded threshold is always one of the four levels
  a_r4_level_legal: assert property (@(posedge clk) disable iff (rst)
    (level == CNT_W'(LVL0)) || (level == CNT_W'(LVL1)) ||
    (level == CNT_W'(LVL2)) || (level == CNT_W'(LVL3)));

endmodule

// File: rtl/nrts_req_mux.sv
module nrts_req_mux #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic [CNT_W-1:0] level,
  input  logic             auto_en,
  input  logic             sw_rts,
  output logic             req
);
  import nrts_pkg::*;

  rts_mode_e mode;
  logic      room;

  always_comb begin
    mode = auto_en ? MODE_AUTO : MODE_SW;
    room = (fifo_count < level);
    case (mode)
      MODE_AUTO: req = room;
      default:   req = sw_rts;
    endcase
  end

  // R3: count at or past the threshold withdraws the request
  a_r3_full_withdraws: assert property (@(posedge clk) disable iff (rst)
    (auto_en && (fifo_count >= level)) |-> !req);

  // R2: count below the threshold keeps the request
  a_r2_room_requests: assert property (@(posedge clk) disable iff (rst)
    (auto_en && (fifo_count < level)) |-> req);

  // R5: software mode follows the control bit
  a_r5_sw_follow: assert property (@(posedge clk) disable iff (rst)
    !auto_en |-> (req == sw_rts));

endmodule

// File: rtl/nrts_pin_stage.sv
module nrts_pin_stage #(
  parameter logic PIN_RST = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic pol_inv,
  output logic pin
);
  logic pin_q;

  always_ff @(posedge clk) begin
    if (rst) pin_q <= PIN_RST;
    else     pin_q <= pol_inv ? ~req : req;
  end

  assign pin = pin_q;

  // R6: pin reflects the request through the selected polarity one edge later
  a_r6_polarity: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pin == ($past(pol_inv) ? ~$past(req) : $past(req))));

  // R8: no change on the pin while its inputs hold
  a_r8_quiet: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(req) && $stable(pol_inv)) |=> $stable(pin));

endmodule

// File: rtl/nrts_gen.sv
module nrts_gen #(
  parameter int unsigned CNT_W = 5,
  parameter int unsigned LVL0  = 1,
  parameter int unsigned LVL1  = 4,
  parameter int unsigned LVL2  = 8,
  parameter int unsigned LVL3  = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic [3:0]       trig_code,
  input  logic             auto_en,
  input  logic             sw_rts,
  input  logic             pol_inv,
  output logic             rts_n_pin,
  output logic             rts_pin_status
);
  localparam logic PIN_IDLE = 1'b1;

  logic [CNT_W-1:0] level;
  logic             req;
  logic             pin;

  nrts_trig_decode #(
    .CNT_W(CNT_W), .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3)
  ) u_dec (
    .clk(clk), .rst(rst), .trig_code(trig_code), .level(level)
  );

  nrts_req_mux #(.CNT_W(CNT_W)) u_mux (
    .clk(clk), .rst(rst), .fifo_count(fifo_count), .level(level),
    .auto_en(auto_en), .sw_rts(sw_rts), .req(req)
  );

  nrts_pin_stage #(.PIN_RST(PIN_IDLE)) u_pin (
    .clk(clk), .rst(rst), .req(req), .pol_inv(pol_inv), .pin(pin)
  );

  assign rts_n_pin      = pin;
  assign rts_pin_status = pin;

  // R1: reset forces the idle level on the pin
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (rts_n_pin == PIN_IDLE));

  // R7: readback matches the pin
  a_r7_status_match: assert property (@(posedge clk) disable iff (rst)
    rts_pin_status == rts_n_pin);

endmodule

// File: tb/nrts_gen_test.sv
module nrts_gen_test;
  localparam int unsigned CNT_W = 5;
  localparam int unsigned CMAX  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [CNT_W-1:0] fifo_count = '0;
  logic [3:0]       trig_code = '0;
  logic             auto_en = 1'b0;
  logic             sw_rts = 1'b0;
  logic             pol_inv = 1'b1;
  logic             rts_n_pin;
  logic             rts_pin_status;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic exp_prev = 1'b1;

  always #5 clk = ~clk;

  nrts_gen #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .fifo_count(fifo_count), .trig_code(trig_code),
    .auto_en(auto_en), .sw_rts(sw_rts), .pol_inv(pol_inv),
    .rts_n_pin(rts_n_pin), .rts_pin_status(rts_pin_status)
  );

  function automatic int unsigned lvl_of(input logic [3:0] c);
    if (c == 4'd0) return 1;
    if (c == 4'd1) return 4;
    if (c == 4'd2) return 8;
    return 14;
  endfunction

  function automatic logic exp_pin(input int unsigned cnt, input logic [3:0] c,
                                   input logic a, input logic s, input logic p);
    logic r;
    r = a ? (cnt < lvl_of(c)) : s;
    return p ? ~r : r;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input int unsigned cnt, input logic [3:0] c,
                      input logic a, input logic s, input logic p);
    logic e;
    @(negedge clk);
    fifo_count = CNT_W'(cnt); trig_code = c; auto_en = a; sw_rts = s; pol_inv = p;
    #1 check("R8 pin held between edges", rts_n_pin, exp_prev);
    e = exp_pin(cnt, c, a, s, p);
    @(posedge clk); #1;
    check(tag, rts_n_pin, e);
    check("R7 status equals pin", rts_pin_status, rts_n_pin);
    exp_prev = e;
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_up();
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    // R1: reset dominates inputs that would drive the pin low
    pol_inv = 1'b0; auto_en = 1'b0; sw_rts = 1'b0;
    repeat (3) @(posedge clk);
    #1 check("R1 reset pin", rts_n_pin, 1'b1);
    check("R1 reset status", rts_pin_status, 1'b1);
    @(negedge clk);
    rst = 1'b0; pol_inv = 1'b1;
    exp_prev = 1'b1;

    // R2 R3 R4 R9: boundaries for every code
    for (int c = 0; c < 16; c++) begin
      int unsigned l;
      l = lvl_of(4'(c));
      step("R2 below threshold", l - 1, 4'(c), 1'b1, 1'b0, 1'b1);
      step("R3 at threshold", l, 4'(c), 1'b1, 1'b0, 1'b1);
      step("R9 count at max", CMAX, 4'(c), 1'b1, 1'b0, 1'b1);
    end
    // R4: reserved codes split at 13/14
    step("R4 reserved code 13 bytes", 13, 4'd9, 1'b1, 1'b0, 1'b0);
    step("R4 reserved code 14 bytes", 14, 4'd9, 1'b1, 1'b0, 1'b0);
    // R5: software mode ignores a full FIFO
    step("R5 sw bit set, full fifo", CMAX, 4'd0, 1'b0, 1'b1, 1'b1);
    step("R5 sw bit clear, empty fifo", 0, 4'd3, 1'b0, 1'b0, 1'b1);
    // R6: both polarities
    step("R6 non-inverted request", 0, 4'd1, 1'b1, 1'b0, 1'b0);
    step("R6 inverted request", 0, 4'd1, 1'b1, 1'b0, 1'b1);
    // R8: mode switch with equal request keeps the pin steady
    step("R8 auto active", 0, 4'd2, 1'b1, 1'b0, 1'b1);
    step("R8 switch to sw active", 0, 4'd2, 1'b0, 1'b1, 1'b1);

    for (int i = 0; i < 400; i++) begin
      int unsigned cnt;
      logic [3:0] c;
      cnt = $urandom_range(CMAX, 0);
      c   = 4'($urandom_range(15, 0));
      step("R2 R3 R5 R6 random", cnt, c, 1'($urandom_range(1, 0)),
           1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)));
    end

    // R1: reset again mid-run
    @(negedge clk);
    rst = 1'b1; auto_en = 1'b1; fifo_count = '0; pol_inv = 1'b0;
    @(posedge clk); #1 check("R1 mid-run reset", rts_n_pin, 1'b1);
    finish_up();
  end
endmodule